// File: doc/BRIEF.md
# Vector Mask Test and Merge Unit

This block keeps a per-element selection mask for a vector datapath. Mask bit i always belongs to vector element i, for 64 elements by default. The mask can be set in two ways. A scalar write replaces the whole mask in one cycle. A condition test builds the mask instead: it runs over a stream of indexed elements and writes one bit for each element whose index lies below the vector length.

Once a mask is in place, the block merges two operand streams element by element. For each indexed pair the mask bit picks which operand becomes the result. Merge results are produced only for indices below the vector length. The current mask is always visible on a scalar read-back port. Vector storage and instruction decode sit outside the block. The vector length comes in from outside as an input.

Top module: `vmask_unit`

## Requirements
- R1: After reset, `mask_rd` is all zeros and `tst_busy`, `tst_done` and `mrg_out_valid` are 0.
- R2: When `ld_valid` is 1 at a clock edge, `mask_rd` equals `ld_data` from the next cycle onward, until the next change.
- R3: Mask bit i (bit 0 the least significant) belongs to element index i, both when a test writes it and when a merge reads it. Index 0 maps to bit 0 and index 63 maps to bit 63.
- R4: The `tst_cond` encoding is: 0 = element equals zero, 1 = element nonzero, 2 = sign bit (MSB) clear, 3 = sign bit set. A tested element writes 1 to its bit when its condition holds, and 0 otherwise.
- R5: An accepted `tst_start` clears the whole mask on the next edge. During the test, only elements with `tst_valid` set and index below the captured length write their bits. Bits at or above that length read 0 when the test ends. Elements presented while no test runs leave the mask unchanged.
- R6: `tst_busy` stays 1 until the number of accepted in-range elements equals the captured length. `tst_done` pulses for one cycle in the cycle after the last such element. With length 0, `tst_done` pulses in the cycle after the start and `tst_busy` stays 0. A length above 64 is treated as 64.
- R7: A scalar load takes priority over a test start in the same cycle: the loaded value wins and no test begins. A load during a running test ends that test at once, without a `tst_done` pulse.
- R8: A merge request at index i yields `mrg_out` one cycle later. The result is `mrg_a` if mask bit i was 1 and `mrg_b` if it was 0.
- R9: `mrg_out_valid` is 1 only in the cycle after a merge request whose index is below `vlen`. A pass over indices 0..63 therefore gives exactly `vlen` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vlen | input | 7 | Vector length, 0..64 |
| ld_valid | input | 1 | Scalar mask write strobe |
| ld_data | input | 64 | Scalar mask value |
| mask_rd | output | 64 | Current mask, read back |
| tst_start | input | 1 | Begin a condition test |
| tst_cond | input | 2 | Condition select |
| tst_valid | input | 1 | Test element strobe |
| tst_idx | input | 6 | Test element index |
| tst_elem | input | 64 | Test element value |
| tst_busy | output | 1 | Test in progress |
| tst_done | output | 1 | One-cycle test completion pulse |
| mrg_valid | input | 1 | Merge request strobe |
| mrg_idx | input | 6 | Merge element index |
| mrg_a | input | 64 | Operand picked when mask bit is 1 |
| mrg_b | input | 64 | Operand picked when mask bit is 0 |
| mrg_out | output | 64 | Merged element |
| mrg_out_valid | output | 1 | Merged element valid |

## Verification
Every mask bit is visible on `mask_rd`, so a bit written at the wrong index or with the wrong condition shows up one cycle after the element edge. The effect also reaches `mrg_out` on the next merge that reads that bit. A wrong captured length or a wrong element count shows up as a `tst_done` pulse in the wrong cycle or a pulse that never comes. It can also show as stale upper bits at the end of the test. A wrong length compare in the merge path changes the number of `mrg_out_valid` cycles in a single 64-index pass.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

  typedef enum logic [1:0] {
    COND_ZERO    = 2'd0,
    COND_NONZERO = 2'd1,
    COND_POS     = 2'd2,
    COND_NEG     = 2'd3
  } cond_e;

  // Condition result from the two element flags.
  function automatic logic cond_hit(input cond_e c, input logic is_zero, input logic sign);
    case (c)
      COND_ZERO:    return is_zero;
      COND_NONZERO: return !is_zero;
      COND_POS:     return !sign;
      default:      return sign;
    endcase
  endfunction

endpackage

// File: rtl/vmask_cond_eval.sv
module vmask_cond_eval
  import vmask_pkg::*;
#(
  parameter int EW = 64
) (
  input  cond_e         cond,
  input  logic [EW-1:0] elem,
  output logic          hit
);
  logic is_zero;
  logic sign;

  assign is_zero = (elem == '0);
  assign sign    = elem[EW-1];
  assign hit     = cond_hit(cond, is_zero, sign);
endmodule

// File: rtl/vmask_test_ctrl.sv
module vmask_test_ctrl
  import vmask_pkg::*;
#(
  parameter int ELEMS = 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int LEN_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [LEN_W-1:0] vl,
  input  cond_e            cond,
  input  logic             elem_valid,
  input  logic [IDX_W-1:0] elem_idx,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output cond_e            cond_q
);
  logic [LEN_W-1:0] vl_q;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cnt_nxt;
  logic             in_range;
  logic             last;

  assign in_range = LEN_W'(elem_idx) < vl_q;
  assign wr_en    = busy && elem_valid && in_range && !start && !abort;
  assign wr_idx   = elem_idx;
  assign cnt_nxt  = cnt + LEN_W'(1);
  assign last     = (cnt_nxt == vl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      vl_q   <= '0;
      cond_q <= COND_ZERO;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        vl_q   <= vl;
        cond_q <= cond;
        cnt    <= '0;
        busy   <= (vl != '0);
        done   <= (vl == '0);
      end else if (wr_en) begin
        cnt <= cnt_nxt;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vmask_store.sv
module vmask_store #(
  parameter int ELEMS = 64,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ELEMS-1:0] load_data,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output logic [ELEMS-1:0] mask
);
  for (genvar i = 0; i < ELEMS; i++) begin : g_bit
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)     mask[i] <= 1'b0;
      else if (load)  mask[i] <= load_data[i];
      else if (clear) mask[i] <= 1'b0;
      else if (sel)   mask[i] <= wr_bit;
    end
  end
endmodule

// File: rtl/vmask_merge.sv
module vmask_merge #(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int LEN_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ELEMS-1:0] mask,
  input  logic [LEN_W-1:0] vl,
  input  logic             req,
  input  logic [IDX_W-1:0] idx,
  input  logic [EW-1:0]    a,
  input  logic [EW-1:0]    b,
  output logic [EW-1:0]    res,
  output logic             res_valid
);
  logic take;

  assign take = req && (LEN_W'(idx) < vl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= take;
      if (req) res <= mask[idx] ? a : b;
    end
  end
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int LEN_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] vlen,
  input  logic             ld_valid,
  input  logic [ELEMS-1:0] ld_data,
  output logic [ELEMS-1:0] mask_rd,
  input  logic             tst_start,
  input  logic [1:0]       tst_cond,
  input  logic             tst_valid,
  input  logic [IDX_W-1:0] tst_idx,
  input  logic [EW-1:0]    tst_elem,
  output logic             tst_busy,
  output logic             tst_done,
  input  logic             mrg_valid,
  input  logic [IDX_W-1:0] mrg_idx,
  input  logic [EW-1:0]    mrg_a,
  input  logic [EW-1:0]    mrg_b,
  output logic [EW-1:0]    mrg_out,
  output logic             mrg_out_valid
);
  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    return (v > LEN_W'(ELEMS)) ? LEN_W'(ELEMS) : v;
  endfunction

  // Named events for the checker
  logic             ld_fire;
  logic             tst_begin;
  logic             tst_wr;
  logic [IDX_W-1:0] tst_wr_idx;
  logic             tst_hit;
  logic [LEN_W-1:0] vl_eff;
  cond_e            cond_live;
  cond_e            cond_run;

  assign ld_fire   = ld_valid;
  assign tst_begin = tst_start && !ld_valid;
  assign vl_eff    = clamp_len(vlen);
  assign cond_live = cond_e'(tst_cond);

  vmask_test_ctrl #(.ELEMS(ELEMS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (tst_begin),
    .abort      (ld_fire),
    .vl         (vl_eff),
    .cond       (cond_live),
    .elem_valid (tst_valid),
    .elem_idx   (tst_idx),
    .busy       (tst_busy),
    .done       (tst_done),
    .wr_en      (tst_wr),
    .wr_idx     (tst_wr_idx),
    .cond_q     (cond_run)
  );

  vmask_cond_eval #(.EW(EW)) u_eval (
    .cond (cond_run),
    .elem (tst_elem),
    .hit  (tst_hit)
  );

  vmask_store #(.ELEMS(ELEMS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld_fire),
    .load_data (ld_data),
    .clear     (tst_begin),
    .wr_en     (tst_wr),
    .wr_idx    (tst_wr_idx),
    .wr_bit    (tst_hit),
    .mask      (mask_rd)
  );

  vmask_merge #(.ELEMS(ELEMS), .EW(EW)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask      (mask_rd),
    .vl        (vl_eff),
    .req       (mrg_valid),
    .idx       (mrg_idx),
    .a         (mrg_a),
    .b         (mrg_b),
    .res       (mrg_out),
    .res_valid (mrg_out_valid)
  );
endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk #(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int LEN_W = $clog2(ELEMS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] vlen,
  input logic             ld_valid,
  input logic [ELEMS-1:0] ld_data,
  input logic [ELEMS-1:0] mask_rd,
  input logic             tst_start,
  input logic             tst_busy,
  input logic             tst_done,
  input logic             tst_begin,
  input logic             mrg_valid,
  input logic [IDX_W-1:0] mrg_idx,
  input logic [EW-1:0]    mrg_a,
  input logic [EW-1:0]    mrg_b,
  input logic [EW-1:0]    mrg_out,
  input logic             mrg_out_valid
);
  logic sel_now;
  assign sel_now = mask_rd[mrg_idx];

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (mask_rd == $past(ld_data))); // R2

  AST_LOAD_BEATS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && tst_start) |=> !tst_busy && !tst_done); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tst_begin |=> (mask_rd == '0)); // R5

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tst_done |-> !tst_busy); // R6

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_begin && vlen == '0) |=> tst_done); // R6

  AST_MERGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mrg_out_valid |-> ($past(mrg_valid) && (LEN_W'($past(mrg_idx)) < $past(vlen)))); // R9

  AST_MERGE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    mrg_out_valid |-> (mrg_out == ($past(sel_now) ? $past(mrg_a) : $past(mrg_b)))); // R8
endmodule

bind vmask_unit vmask_unit_chk #(.ELEMS(ELEMS), .EW(EW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vlen          (vl_eff),
  .ld_valid      (ld_valid),
  .ld_data       (ld_data),
  .mask_rd       (mask_rd),
  .tst_start     (tst_start),
  .tst_busy      (tst_busy),
  .tst_done      (tst_done),
  .tst_begin     (tst_begin),
  .mrg_valid     (mrg_valid),
  .mrg_idx       (mrg_idx),
  .mrg_a         (mrg_a),
  .mrg_b         (mrg_b),
  .mrg_out       (mrg_out),
  .mrg_out_valid (mrg_out_valid)
);

// File: tb/vmask_unit_test.sv
module vmask_unit_test;
  localparam int CLK_P = 10;
  localparam int N     = 64;
  localparam int NCASE = 12;

  // Table entry: {cond[24:23], length[22:16], seed[15:0]}
  localparam logic [24:0] CASES [NCASE] = '{
    {2'd0, 7'd0,  16'h1357},
    {2'd1, 7'd1,  16'h2468},
    {2'd2, 7'd64, 16'h0bad},
    {2'd3, 7'd63, 16'hbeef},
    {2'd0, 7'd17, 16'h4242},
    {2'd1, 7'd33, 16'h9999},
    {2'd2, 7'd5,  16'h7070},
    {2'd3, 7'd40, 16'h00f1},
    {2'd0, 7'd64, 16'h3c3c},
    {2'd3, 7'd2,  16'hcafe},
    {2'd1, 7'd31, 16'h5151},
    {2'd2, 7'd48, 16'hd00d}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    vlen = '0;
  logic          ld_valid = 1'b0;
  logic [63:0]   ld_data = '0;
  logic [63:0]   mask_rd;
  logic          tst_start = 1'b0;
  logic [1:0]    tst_cond = '0;
  logic          tst_valid = 1'b0;
  logic [5:0]    tst_idx = '0;
  logic [63:0]   tst_elem = '0;
  logic          tst_busy;
  logic          tst_done;
  logic          mrg_valid = 1'b0;
  logic [5:0]    mrg_idx = '0;
  logic [63:0]   mrg_a = '0;
  logic [63:0]   mrg_b = '0;
  logic [63:0]   mrg_out;
  logic          mrg_out_valid;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  vmask_unit uut (
    .clk(clk), .rst_n(rst_n), .vlen(vlen),
    .ld_valid(ld_valid), .ld_data(ld_data), .mask_rd(mask_rd),
    .tst_start(tst_start), .tst_cond(tst_cond), .tst_valid(tst_valid),
    .tst_idx(tst_idx), .tst_elem(tst_elem), .tst_busy(tst_busy), .tst_done(tst_done),
    .mrg_valid(mrg_valid), .mrg_idx(mrg_idx), .mrg_a(mrg_a), .mrg_b(mrg_b),
    .mrg_out(mrg_out), .mrg_out_valid(mrg_out_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] gen(input logic [15:0] s, input int i);
    logic [63:0] x;
    x = {s, 16'h5a5a, s ^ 16'hffff, 16'(i)} * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 31);
    if (x[2:0] == 3'd0) x = '0;
    return x;
  endfunction

  // Reference condition, written from the encoding list
  function automatic bit ref_hit(input logic [1:0] c, input logic [63:0] e);
    if (c == 2'd0) return e == 64'd0;
    if (c == 2'd1) return e != 64'd0;
    if (c == 2'd2) return $signed(e) >= 0;
    return $signed(e) < 0;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_mask;
    int          dones;
    int          outs;

    @(negedge clk);
    step();
    // R1 reset state
    check(mask_rd == '0, "R1 mask", mask_rd, '0);
    check({tst_busy, tst_done, mrg_out_valid} == 3'b000, "R1 flags",
          64'({tst_busy, tst_done, mrg_out_valid}), '0);
    rst_n = 1'b1;
    step();

    // Table walk: test builds mask, merge pass reads it
    for (int k = 0; k < NCASE; k++) begin
      logic [1:0]  c;
      logic [6:0]  vl;
      logic [15:0] sd;
      c  = CASES[k][24:23];
      vl = CASES[k][22:16];
      sd = CASES[k][15:0];
      exp_mask = '0;
      for (int i = 0; i < N; i++)
        if (i < int'(vl) && ref_hit(c, gen(sd, i))) exp_mask[i] = 1'b1;
      ld_valid = 1'b1; ld_data = ~64'd0; step(); ld_valid = 1'b0;
      vlen = vl; tst_cond = c; tst_start = 1'b1;
      step();
      tst_start = 1'b0;
      dones = tst_done ? 1 : 0;
      check(tst_busy == (vl != 0), "R6 busy after start", 64'(tst_busy), 64'(vl != 0));
      for (int i = 0; i < N; i++) begin
        tst_valid = 1'b1; tst_idx = 6'(i); tst_elem = gen(sd, i);
        step();
        if (tst_done) dones++;
      end
      tst_valid = 1'b0;
      step();
      if (tst_done) dones++;
      check(dones == 1, "R6 one done pulse", 64'(dones), 64'd1);
      check(!tst_busy, "R6 idle at end", 64'(tst_busy), 0);
      check(mask_rd == exp_mask, "R4 R5 test mask", mask_rd, exp_mask);

      outs = 0;
      for (int i = 0; i < N; i++) begin
        logic [63:0] av, bv;
        av = gen(sd ^ 16'h0001, i);
        bv = gen(sd ^ 16'h0002, i);
        mrg_valid = 1'b1; mrg_idx = 6'(i); mrg_a = av; mrg_b = bv;
        step();
        if (mrg_out_valid) outs++;
        if (i < int'(vl))
          check(mrg_out_valid && mrg_out == (exp_mask[i] ? av : bv), "R8 merge pick",
                mrg_out, exp_mask[i] ? av : bv);
        else
          check(!mrg_out_valid, "R9 no result past length", 64'(mrg_out_valid), 0);
      end
      mrg_valid = 1'b0;
      check(outs == int'(vl), "R9 result count", 64'(outs), 64'(vl));
    end

    // R2 R10-style read-back after scalar load
    ld_valid = 1'b1; ld_data = 64'h8000_0000_0000_0001; step(); ld_valid = 1'b0;
    check(mask_rd == 64'h8000_0000_0000_0001, "R2 load", mask_rd, 64'h8000_0000_0000_0001);
    // R3 bit 0 and bit 63 map to elements 0 and 63
    vlen = 7'd64;
    mrg_valid = 1'b1; mrg_idx = 6'd0; mrg_a = 64'hAAAA; mrg_b = 64'hBBBB; step();
    check(mrg_out == 64'hAAAA, "R3 element 0", mrg_out, 64'hAAAA);
    mrg_idx = 6'd63; step();
    check(mrg_out == 64'hAAAA, "R3 element 63", mrg_out, 64'hAAAA);
    mrg_idx = 6'd62; step(); mrg_valid = 1'b0;
    check(mrg_out == 64'hBBBB, "R3 element 62", mrg_out, 64'hBBBB);
    // R3 test writes bit 63 from element 63
    tst_cond = 2'd3; tst_start = 1'b1; step(); tst_start = 1'b0;
    for (int i = 0; i < N; i++) begin
      tst_valid = 1'b1; tst_idx = 6'(i);
      tst_elem = (i == 63) ? 64'h8000_0000_0000_0000 : 64'd5;
      step();
    end
    tst_valid = 1'b0;
    check(mask_rd == 64'h8000_0000_0000_0000, "R3 test bit 63", mask_rd, 64'h8000_0000_0000_0000);

    // R7 load wins over same-cycle start
    ld_valid = 1'b1; ld_data = 64'h1234_5678_9abc_def0; tst_start = 1'b1; vlen = 7'd10;
    step();
    ld_valid = 1'b0; tst_start = 1'b0;
    check(mask_rd == 64'h1234_5678_9abc_def0, "R7 load priority", mask_rd, 64'h1234_5678_9abc_def0);
    check(!tst_busy, "R7 no test begun", 64'(tst_busy), 0);

    // R7 load aborts a running test
    tst_cond = 2'd1; tst_start = 1'b1; step(); tst_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tst_valid = 1'b1; tst_idx = 6'(i); tst_elem = 64'd7; step();
    end
    tst_valid = 1'b0;
    ld_valid = 1'b1; ld_data = 64'hF0F0; step(); ld_valid = 1'b0;
    check(!tst_busy && !tst_done, "R7 abort", 64'({tst_busy, tst_done}), 0);
    // R5 elements while idle leave mask alone
    for (int i = 3; i < 10; i++) begin
      tst_valid = 1'b1; tst_idx = 6'(i); tst_elem = 64'd9; step();
      check(!tst_done, "R7 no done after abort", 64'(tst_done), 0);
    end
    tst_valid = 1'b0;
    check(mask_rd == 64'hF0F0, "R5 idle elements ignored", mask_rd, 64'hF0F0);

    // R6 length above 64 clamps to 64
    vlen = 7'd100; tst_cond = 2'd1; tst_start = 1'b1; step(); tst_start = 1'b0;
    dones = 0;
    for (int i = 0; i < N; i++) begin
      tst_valid = 1'b1; tst_idx = 6'(i); tst_elem = 64'd1; step();
      if (tst_done) dones++;
    end
    tst_valid = 1'b0;
    check(dones == 1 && mask_rd == ~64'd0, "R6 clamp", mask_rd, ~64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule